// File: doc/BRIEF.md
# Stack Limit Guard

This block stands beside a processor's store path and watches every write made relative to the process stack pointer. Software programs a lower bound into a limit register. Each presented stack write address is compared with the stored bound in the same cycle. A write that would land below the bound is refused: its memory write-enable is withheld, and a fault pulse is raised.

When a write is refused, a sticky overflow flag is set in a small status word. Software clears that flag by writing one to its bit. The fault pulse goes to the usage-fault output when the routing enable is high. When the routing enable is low, the fault escalates to the hard-fault output.

The limit register keeps only 8-byte aligned values, because it discards the low address bits of whatever is written to it. A write exactly at the bound is legal. If software asks for a bound that is 4 modulo 8, the stored bound is therefore one word lower than requested, and the word just below the requested bound can be written without a fault.

Top module: `stack_limit_guard`

## Requirements
- R1: A valid stack write whose address is strictly less than the stored limit (unsigned) raises a fault in the same cycle it is presented.
- R2: A valid stack write whose address is equal to or greater than the stored limit raises no fault and is passed to memory; a write at the stored bound followed by a write one word lower faults only on the second.
- R3: Writing the limit register clears the low 3 bits of the written value, so the stored and read-back limit is always a multiple of 8 (written 0x2000185C reads 0x20001858).
- R4: On the clock edge ending a faulting cycle, bit 4 of the 8-bit status word is set; all other status bits always read 0.
- R5: A fault drives the usage-fault output when the route enable is 1, and the hard-fault output when it is 0; the two outputs are never high together.
- R6: The memory write-enable equals the access valid, except that it is 0 in any cycle where a fault is raised.
- R7: The overflow bit stays set until a status write has bit 4 set; a status write with bit 4 clear has no effect; a fault in the same cycle as a clearing write leaves the bit set.
- R8: Reset sets the limit and the status word to 0, so no address faults until a limit is programmed.
- R9: The fault outputs are combinational, high only in cycles where the access valid is high, and so give one pulse per single-cycle faulting access.
- R10: A limit write takes effect from the next cycle; an access in the same cycle as the write is compared against the previous limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lim_wr_en | input | 1 | Limit register write strobe |
| lim_wr_data | input | ADDR_W | Requested limit value |
| lim_rd_data | output | ADDR_W | Stored, aligned limit |
| acc_valid | input | 1 | Stack write request present |
| acc_addr | input | ADDR_W | Stack write address |
| route_usage_en | input | 1 | 1 sends faults to usage fault, 0 to hard fault |
| sts_wr_en | input | 1 | Status write strobe (write-one-to-clear) |
| sts_wr_data | input | 8 | Status write data, bit 4 clears overflow |
| sts_rd_data | output | 8 | Status word, bit 4 is overflow |
| mem_we | output | 1 | Write-enable passed to memory |
| usage_fault | output | 1 | Usage-fault pulse |
| hard_fault | output | 1 | Hard-fault pulse |

## Verification
A wrong stored limit shows on the limit read-back at once. It also shows at the fault outputs on the first access near the bound, where the bound-equal and one-word-below cases separate an off-by-one compare from a correct one. A flipped routing or sticky state appears at the fault outputs in the same cycle, or in the status word one edge later. The bench probes same-cycle collisions, such as a limit write with an access or a clear with a fault, because ordering mistakes in those collisions show only there.

// File: rtl/slg_pkg.sv
package slg_pkg;

    localparam int STS_W   = 8;
    localparam int OVF_BIT = 4;

    typedef enum logic [1:0] {
        ROUTE_NONE  = 2'd0,
        ROUTE_USAGE = 2'd1,
        ROUTE_HARD  = 2'd2
    } route_e;

    typedef struct packed {
        logic   below;
        route_e route;
    } verdict_t;

    function automatic route_e pick_route(input logic below, input logic usage_en);
        if (!below)        return ROUTE_NONE;
        else if (usage_en) return ROUTE_USAGE;
        else               return ROUTE_HARD;
    endfunction

endpackage

// File: rtl/slg_limit_reg.sv
module slg_limit_reg #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] limit
);

    logic [ADDR_W-1:0] aligned;

    generate
        if (ALIGN_LOG2 > 0) begin : g_mask
            assign aligned = {wr_data[ADDR_W-1:ALIGN_LOG2], {ALIGN_LOG2{1'b0}}};
        end else begin : g_pass
            assign aligned = wr_data;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)        limit <= '0;
        else if (wr_en) limit <= aligned;
    end

endmodule

// File: rtl/slg_bound_cmp.sv
module slg_bound_cmp
    import slg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] limit,
    input  logic              usage_en,
    output verdict_t          verdict
);

    always_comb begin
        verdict.below = valid && (addr < limit);
        verdict.route = pick_route(verdict.below, usage_en);
    end

endmodule

// File: rtl/slg_status.sv
module slg_status
    import slg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set,
    input  logic             clr_we,
    input  logic [STS_W-1:0] clr_data,
    output logic [STS_W-1:0] status
);

    logic ovf_q;

    always_ff @(posedge clk) begin
        if (rst)                             ovf_q <= 1'b0;
        else if (set)                        ovf_q <= 1'b1;
        else if (clr_we && clr_data[OVF_BIT]) ovf_q <= 1'b0;
    end

    always_comb begin
        status          = '0;
        status[OVF_BIT] = ovf_q;
    end

endmodule

// File: rtl/stack_limit_guard.sv
module stack_limit_guard
    import slg_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lim_wr_en,
    input  logic [ADDR_W-1:0] lim_wr_data,
    output logic [ADDR_W-1:0] lim_rd_data,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              route_usage_en,
    input  logic              sts_wr_en,
    input  logic [7:0]        sts_wr_data,
    output logic [7:0]        sts_rd_data,
    output logic              mem_we,
    output logic              usage_fault,
    output logic              hard_fault
);

    logic [ADDR_W-1:0] limit_q;
    verdict_t          verdict;

    slg_limit_reg #(.ADDR_W(ADDR_W), .ALIGN_LOG2(ALIGN_LOG2)) u_limit (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (lim_wr_en),
        .wr_data (lim_wr_data),
        .limit   (limit_q)
    );

    slg_bound_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .valid    (acc_valid),
        .addr     (acc_addr),
        .limit    (limit_q),
        .usage_en (route_usage_en),
        .verdict  (verdict)
    );

    slg_status u_sts (
        .clk      (clk),
        .rst      (rst),
        .set      (verdict.below),
        .clr_we   (sts_wr_en),
        .clr_data (sts_wr_data),
        .status   (sts_rd_data)
    );

    assign lim_rd_data = limit_q;
    assign mem_we      = acc_valid && !verdict.below;
    assign usage_fault = (verdict.route == ROUTE_USAGE);
    assign hard_fault  = (verdict.route == ROUTE_HARD);

endmodule

// File: rtl/slg_checker.sv
module slg_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] lim_rd_data,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              route_usage_en,
    input logic              sts_wr_en,
    input logic [7:0]        sts_wr_data,
    input logic [7:0]        sts_rd_data,
    input logic              mem_we,
    input logic              usage_fault,
    input logic              hard_fault
);

    p_below_faults_r1: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_addr < lim_rd_data) |-> (usage_fault || hard_fault));

    p_at_or_above_ok_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_addr >= lim_rd_data) |-> (!usage_fault && !hard_fault && mem_we));

    p_limit_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        lim_rd_data[2:0] == 3'b000);

    p_fault_sets_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (usage_fault || hard_fault) |=> sts_rd_data[4]);

    p_other_bits_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (sts_rd_data & 8'hEF) == 8'h00);

    p_route_usage_r5: assert property (@(posedge clk) disable iff (rst)
        usage_fault |-> route_usage_en);

    p_route_hard_r5: assert property (@(posedge clk) disable iff (rst)
        hard_fault |-> !route_usage_en);

    p_one_fault_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({usage_fault, hard_fault}));

    p_block_write_r6: assert property (@(posedge clk) disable iff (rst)
        (usage_fault || hard_fault) |-> !mem_we);

    p_flag_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (sts_rd_data[4] && !(sts_wr_en && sts_wr_data[4])) |=> sts_rd_data[4]);

    p_reset_clear_r8: assert property (@(posedge clk)
        $fell(rst) |-> (lim_rd_data == '0 && sts_rd_data == 8'h00));

    p_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (!usage_fault && !hard_fault && !mem_we));

endmodule

bind stack_limit_guard slg_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .lim_rd_data    (lim_rd_data),
    .acc_valid      (acc_valid),
    .acc_addr       (acc_addr),
    .route_usage_en (route_usage_en),
    .sts_wr_en      (sts_wr_en),
    .sts_wr_data    (sts_wr_data),
    .sts_rd_data    (sts_rd_data),
    .mem_we         (mem_we),
    .usage_fault    (usage_fault),
    .hard_fault     (hard_fault)
);

// File: tb/stack_limit_guard_test.sv
`timescale 1ns/1ps
module stack_limit_guard_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lim_wr_en = 1'b0;
    logic [31:0] lim_wr_data = '0;
    logic [31:0] lim_rd_data;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        route_usage_en = 1'b1;
    logic        sts_wr_en = 1'b0;
    logic [7:0]  sts_wr_data = '0;
    logic [7:0]  sts_rd_data;
    logic        mem_we, usage_fault, hard_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stack_limit_guard uut (
        .clk(clk), .rst(rst),
        .lim_wr_en(lim_wr_en), .lim_wr_data(lim_wr_data), .lim_rd_data(lim_rd_data),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .route_usage_en(route_usage_en),
        .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .sts_rd_data(sts_rd_data),
        .mem_we(mem_we), .usage_fault(usage_fault), .hard_fault(hard_fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // settle on negedge, drive, let combinational logic settle
    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        lim_wr_en = 0; acc_valid = 0; sts_wr_en = 0; sts_wr_data = '0;
    endtask

    task automatic write_limit(input logic [31:0] v);
        step(); idle_inputs(); lim_wr_en = 1; lim_wr_data = v;
        step(); lim_wr_en = 0;
    endtask

    task automatic t_reset();
        chk("R8 limit after reset", lim_rd_data, 32'h0);
        chk("R8 status after reset", {24'h0, sts_rd_data}, 32'h0);
        acc_valid = 1; acc_addr = 32'h0; #1;
        chk("R8 addr 0 no fault", {30'h0, usage_fault, hard_fault}, 32'h0);
        chk("R8 addr 0 passed", {31'h0, mem_we}, 32'h1);
        step(); idle_inputs();
    endtask

    task automatic t_align();
        write_limit(32'h2000_1867);
        chk("R3 0x..867 stored", lim_rd_data, 32'h2000_1860);
        write_limit(32'h2000_185C);
        chk("R3 0x..85C stored", lim_rd_data, 32'h2000_1858);
    endtask

    task automatic t_edge();
        route_usage_en = 1;
        acc_valid = 1; acc_addr = 32'h2000_1858; #1;
        chk("R2 at bound no fault", {30'h0, usage_fault, hard_fault}, 32'h0);
        chk("R6 at bound passed", {31'h0, mem_we}, 32'h1);
        step(); idle_inputs(); #1;
        chk("R2 status clean after legal write", {24'h0, sts_rd_data}, 32'h0);
        acc_valid = 1; acc_addr = 32'h2000_1854; #1;
        chk("R1 below bound usage fault", {30'h0, usage_fault, hard_fault}, 32'h2);
        chk("R6 below bound blocked", {31'h0, mem_we}, 32'h0);
        step(); idle_inputs(); #1;
        chk("R4 overflow flag set", {24'h0, sts_rd_data}, 32'h10);
        chk("R9 pulse ends", {30'h0, usage_fault, hard_fault}, 32'h0);
        acc_valid = 1; acc_addr = 32'hFFFF_FFFC; #1;
        chk("R2 high address passes", {29'h0, usage_fault, hard_fault, mem_we}, 32'h1);
        step(); idle_inputs();
    endtask

    task automatic t_route();
        route_usage_en = 0;
        acc_valid = 1; acc_addr = 32'h0000_0100; #1;
        chk("R5 hard fault route", {30'h0, usage_fault, hard_fault}, 32'h1);
        step(); idle_inputs(); route_usage_en = 1;
    endtask

    task automatic t_clear();
        sts_wr_en = 1; sts_wr_data = 8'hEF;
        step(); idle_inputs(); #1;
        chk("R7 write without bit 4 ignored", {24'h0, sts_rd_data}, 32'h10);
        sts_wr_en = 1; sts_wr_data = 8'h10;
        step(); idle_inputs(); #1;
        chk("R7 clear by writing one", {24'h0, sts_rd_data}, 32'h0);
        sts_wr_en = 1; sts_wr_data = 8'h10;
        acc_valid = 1; acc_addr = 32'h2000_1850;
        step(); idle_inputs(); #1;
        chk("R7 fault beats clear", {24'h0, sts_rd_data}, 32'h10);
        sts_wr_en = 1; sts_wr_data = 8'hFF;
        step(); idle_inputs(); #1;
        chk("R7 cleared again", {24'h0, sts_rd_data}, 32'h0);
    endtask

    task automatic t_novalid();
        acc_valid = 0; acc_addr = 32'h0000_0004; #1;
        chk("R9 no fault without valid", {29'h0, usage_fault, hard_fault, mem_we}, 32'h0);
        step(); #1;
        chk("R9 status untouched", {24'h0, sts_rd_data}, 32'h0);
    endtask

    task automatic t_write_timing();
        lim_wr_en = 1; lim_wr_data = 32'h3000_0000;
        acc_valid = 1; acc_addr = 32'h2FFF_FFF8; #1;
        chk("R10 old limit used same cycle", {29'h0, usage_fault, hard_fault, mem_we}, 32'h1);
        step(); lim_wr_en = 0; #1;
        chk("R10 new limit next cycle", {29'h0, usage_fault, hard_fault, mem_we}, 32'h4);
        step(); idle_inputs();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        t_reset();
        t_align();
        t_edge();
        t_route();
        t_clear();
        t_novalid();
        t_write_timing();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(8 * 200000);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule